// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Entry Sequencer

This block sits beside a 16-bit little-endian processor core and takes over the core during interrupt entry. Four level-sensitive request lines form a 4-bit request code. A fixed table maps that code to a priority level and a default vector. The priority is compared with the priority field of the core's status word, and the block enters only when the request priority is strictly higher.

On entry the block reads the new PC from the vector address and the new status word from the vector address plus two. It then pushes the old status word and the old PC on the stack, each push one word lower than the last. In a single completion cycle it hands the new PC, status word and stack pointer back to the core, together with a pulse that clears the core's wait state and a cycle cost to charge. An external device may supply the vector in place of the table value. In the completion cycle the block arbitrates again against the newly loaded priority, so a still-pending higher request chains straight into another entry.

The memory side is a plain request/ready port. One word access is outstanding at a time, and it is held until ready is seen.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset, busy, mem_req and entry_done are all 0.
- R2: Request code c (irq_lines) maps to a priority and vector as follows. Code 0 has priority 0 and is never taken. Codes 1..3 have priority 4 and vectors 0x38, 0x34, 0x30. Codes 4..7 have priority 5 and vectors 0x5C, 0x58, 0x54, 0x50. Codes 8..11 have priority 6 and vectors 0x4C, 0x48, 0x44, 0x40. Codes 12..15 have priority 7 and vectors 0x6C, 0x68, 0x64, 0x60. The first access of an entry is a read at that vector.
- R3: An entry starts only when the table priority is strictly greater than status bits 7:5. An equal or lower priority leaves busy and mem_req at 0.
- R4: Accesses run in this order: read at vector, read at vector+2, write of old status at SP-2, write of old PC at SP-4.
- R5: Every memory address has bit 0 forced to 0. The returned stack pointer is exactly SP-4, with no alignment applied.
- R6: entry_done is a one-cycle pulse. During it, new_pc holds the word read from the vector, new_psw holds the word read from vector+2, and new_sp holds SP-4.
- R7: While ack_strobe is high, asserting ack_valid replaces the table vector with ack_vector, with its two low bits cleared.
- R8: In the entry_done cycle the block arbitrates against the newly loaded status. If the request still wins, the next entry starts at once, without busy falling, and uses the new PC, the new status and SP-4 as its old context.
- R9: busy stays high from acceptance through entry_done. mem_req, mem_addr and mem_we hold steady until mem_rdy is seen, and each access advances only on mem_rdy.
- R10: entry_cost equals ENTRY_COST (114 by default) whenever entry_done is high. entry_done is the wait-clear indication to the core.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_lines | input | 4 | Level-sensitive request lines forming the request code |
| core_pc | input | 16 | Core's current PC |
| core_sp | input | 16 | Core's current stack pointer |
| core_psw | input | 16 | Core's current status word; bits 7:5 are the priority |
| ack_strobe | output | 1 | High when a winning request is being accepted |
| ack_code | output | 4 | Request code offered for external acknowledge |
| ack_valid | input | 1 | External vector is valid |
| ack_vector | input | 16 | Externally supplied vector |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Word address, bit 0 always 0 |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with mem_rdy |
| mem_rdy | input | 1 | Access complete |
| busy | output | 1 | Holds off the core's normal execution |
| entry_done | output | 1 | Completion pulse; also clears the core's wait state |
| new_pc | output | 16 | PC to load into the core |
| new_sp | output | 16 | Stack pointer to load into the core |
| new_psw | output | 16 | Status word to load into the core |
| entry_cost | output | 8 | Cycles to charge, valid with entry_done |

## Verification
The bench builds the block with its default parameters: 16-bit address and data and an entry cost of 114. With these values the whole 16-code table, the vector area and a stack just below 0x100 all fit in a 128-word memory model. The memory model's latency is set to 0 and to 3. The zero setting reaches the shortest five-cycle entry and back-to-back chained entries. The three-cycle setting exercises the hold-until-ready behaviour on every access.

// File: rtl/irq_entry_seq.sv
module irq_entry_seq #(
  parameter int AW         = 16,
  parameter int DW         = 16,
  parameter int ENTRY_COST = 114,
  parameter int COST_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        irq_lines,
  input  logic [AW-1:0]     core_pc,
  input  logic [AW-1:0]     core_sp,
  input  logic [DW-1:0]     core_psw,
  output logic              ack_strobe,
  output logic [3:0]        ack_code,
  input  logic              ack_valid,
  input  logic [AW-1:0]     ack_vector,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_wdata,
  input  logic [DW-1:0]     mem_rdata,
  input  logic              mem_rdy,
  output logic              busy,
  output logic              entry_done,
  output logic [AW-1:0]     new_pc,
  output logic [AW-1:0]     new_sp,
  output logic [DW-1:0]     new_psw,
  output logic [COST_W-1:0] entry_cost
);
  localparam int PRIO_LSB = 5;
  localparam logic [AW-1:0] WORD_MASK = ~AW'(1);
  localparam logic [AW-1:0] VEC_MASK  = ~AW'(3);

  typedef enum logic [2:0] {S_IDLE, S_RD_PC, S_RD_PSW, S_PUSH_PSW, S_PUSH_PC, S_LOAD} state_t;
  state_t state;

  logic [AW-1:0] vec_r, pc_r, sp_r, npc_r;
  logic [DW-1:0] psw_r, npsw_r;

  logic [2:0]    cur_prio, req_prio;
  logic          win, arb_slot;
  logic [AW-1:0] tbl_base, tbl_vec, sel_vec;

  assign arb_slot = (state == S_IDLE) || (state == S_LOAD);
  assign cur_prio = (state == S_LOAD) ? npsw_r[PRIO_LSB+2:PRIO_LSB] : core_psw[PRIO_LSB+2:PRIO_LSB];
  assign req_prio = (irq_lines == 4'd0) ? 3'd0 : {1'b1, irq_lines[3:2]};
  assign win      = req_prio > cur_prio;

  always_comb begin
    case (irq_lines[3:2])
      2'd0:    tbl_base = AW'(16'h0030);
      2'd1:    tbl_base = AW'(16'h0050);
      2'd2:    tbl_base = AW'(16'h0040);
      default: tbl_base = AW'(16'h0060);
    endcase
  end
  assign tbl_vec = tbl_base + AW'({~irq_lines[1:0], 2'b00});
  assign sel_vec = (ack_valid ? ack_vector : tbl_vec) & VEC_MASK;

  assign ack_strobe = arb_slot && win;
  assign ack_code   = irq_lines;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      vec_r  <= '0;
      pc_r   <= '0;
      sp_r   <= '0;
      psw_r  <= '0;
      npc_r  <= '0;
      npsw_r <= '0;
    end else begin
      case (state)
        S_IDLE: if (win) begin
          vec_r <= sel_vec;
          pc_r  <= core_pc;
          sp_r  <= core_sp;
          psw_r <= core_psw;
          state <= S_RD_PC;
        end
        S_RD_PC: if (mem_rdy) begin
          npc_r <= mem_rdata;
          state <= S_RD_PSW;
        end
        S_RD_PSW: if (mem_rdy) begin
          npsw_r <= mem_rdata;
          state  <= S_PUSH_PSW;
        end
        S_PUSH_PSW: if (mem_rdy) state <= S_PUSH_PC;
        S_PUSH_PC:  if (mem_rdy) state <= S_LOAD;
        S_LOAD: begin
          if (win) begin
            vec_r <= sel_vec;
            pc_r  <= npc_r;
            sp_r  <= sp_r - AW'(4);
            psw_r <= npsw_r;
            state <= S_RD_PC;
          end else begin
            state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    case (state)
      S_RD_PC:    begin mem_req = 1'b1; mem_addr = vec_r & WORD_MASK; end
      S_RD_PSW:   begin mem_req = 1'b1; mem_addr = (vec_r + AW'(2)) & WORD_MASK; end
      S_PUSH_PSW: begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = (sp_r - AW'(2)) & WORD_MASK; mem_wdata = psw_r; end
      S_PUSH_PC:  begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = (sp_r - AW'(4)) & WORD_MASK; mem_wdata = DW'(pc_r); end
      default: ;
    endcase
  end

  assign busy       = (state != S_IDLE);
  assign entry_done = (state == S_LOAD);
  assign new_pc     = npc_r;
  assign new_psw    = npsw_r;
  assign new_sp     = sp_r - AW'(4);
  assign entry_cost = entry_done ? COST_W'(ENTRY_COST) : '0;
endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_rdy,
  input logic [AW-1:0] mem_addr,
  input logic          entry_done
);
  assert_hold_until_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_rdy |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  assert_no_access_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);

  assert_word_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !mem_addr[0]);

  assert_last_access_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    entry_done |-> $past(mem_req) && $past(mem_we));

  assert_done_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    entry_done |=> !entry_done);
endmodule

bind irq_entry_seq irq_entry_seq_chk #(.AW(AW)) chk (.*);

// File: tb/tb_irq_entry_seq.sv
module tb_irq_entry_seq;
  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic [3:0]  irq_lines = 0;
  logic [15:0] core_pc = 0, core_sp = 0, core_psw = 0;
  logic        ack_strobe, ack_valid = 0;
  logic [3:0]  ack_code;
  logic [15:0] ack_vector = 0;
  logic        mem_req, mem_we, mem_rdy;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;
  logic        busy, entry_done;
  logic [15:0] new_pc, new_sp, new_psw;
  logic [7:0]  entry_cost;

  irq_entry_seq dut (.*);

  logic [15:0] mem [128];
  int lat = 0, wcnt = 0;
  assign mem_rdy   = mem_req && (wcnt == lat);
  assign mem_rdata = mem[mem_addr[7:1]];
  always @(posedge clk) begin
    if (mem_req && mem_rdy) begin
      wcnt <= 0;
      if (mem_we) mem[mem_addr[7:1]] <= mem_wdata;
    end else if (mem_req) wcnt <= wcnt + 1;
  end

  int checks = 0, fails = 0;
  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s actual=%h expected=%h", req, act, exp); end
  endtask

  task automatic wait_first_req(output bit ok);
    ok = 0;
    for (int i = 0; i < 200; i++) begin @(negedge clk); if (mem_req) begin ok = 1; return; end end
  endtask

  task automatic wait_done(output bit ok, output int bcycles);
    ok = 0; bcycles = 0;
    for (int i = 0; i < 400; i++) begin
      if (busy) bcycles++;
      if (entry_done) begin ok = 1; return; end
      @(negedge clk);
    end
  endtask

  task automatic entry(input logic [3:0] code, input logic [15:0] pc, input logic [15:0] sp,
                       input logic [15:0] psw, input logic [15:0] vec,
                       input logic [15:0] vpc, input logic [15:0] vpsw, input string tag);
    bit ok; int bc;
    logic [15:0] sa;
    mem[vec[7:1]] = vpc; mem[vec[7:1] + 1] = vpsw;
    @(negedge clk);
    core_pc = pc; core_sp = sp; core_psw = psw; irq_lines = code;
    wait_first_req(ok);
    chk(ok && mem_addr == vec && !mem_we, {tag, " R2 first access at vector"}, mem_addr, vec);
    wait_done(ok, bc);
    if (!ok) begin chk(0, {tag, " watchdog R6"}, 0, 1); return; end
    chk(new_pc == vpc && new_psw == vpsw, {tag, " R6 loaded pc/psw"}, {new_pc, new_psw}, {vpc, vpsw});
    chk(new_sp == sp - 16'd4, {tag, " R5 new sp"}, new_sp, sp - 16'd4);
    chk(entry_cost == 8'd114, {tag, " R10 cost"}, entry_cost, 114);
    sa = (sp - 16'd2) & 16'hFFFE;
    chk(mem[sa[7:1]] == psw && mem[sa[7:1] - 1] == pc, {tag, " R4 stack contents"},
        {mem[sa[7:1]], mem[sa[7:1] - 1]}, {psw, pc});
    irq_lines = 0; core_psw = new_psw; core_pc = new_pc; core_sp = new_sp;
    @(negedge clk);
    chk(!busy && !entry_done, {tag, " R6 pulse ends"}, {busy, entry_done}, 0);
  endtask

  task automatic t_reset;
    chk(!busy && !mem_req && !entry_done, "R1 reset state", {busy, mem_req, entry_done}, 0);
  endtask

  task automatic t_equal_prio;
    bit any = 0;
    @(negedge clk);
    core_psw = 16'h00A0; irq_lines = 4'd4;
    for (int i = 0; i < 10; i++) begin @(negedge clk); if (busy || mem_req) any = 1; end
    chk(!any, "R3 equal priority not taken", any, 0);
    core_psw = 16'h00C0; irq_lines = 4'd11;
    any = 0;
    for (int i = 0; i < 10; i++) begin @(negedge clk); if (busy || mem_req) any = 1; end
    chk(!any, "R3 equal priority 6 not taken", any, 0);
    irq_lines = 4'd0; core_psw = 0;
    any = 0;
    for (int i = 0; i < 5; i++) begin @(negedge clk); if (busy) any = 1; end
    chk(!any, "R2 code 0 never taken", any, 0);
  endtask

  task automatic t_table;
    logic [15:0] base, v;
    for (int c = 1; c < 16; c++) begin
      case (c / 4) 0: base = 16'h30; 1: base = 16'h50; 2: base = 16'h40; default: base = 16'h60; endcase
      v = base + 16'((3 - (c % 4)) * 4);
      entry(4'(c), 16'h1000 + 16'(c), 16'h00FE, 16'h0000, v, 16'h2000 + 16'(c), 16'h00E0, "table");
      core_psw = 0;
    end
  endtask

  task automatic t_prio_boundary;
    entry(4'd12, 16'h0400, 16'h00FE, 16'h00CF, 16'h006C, 16'h0500, 16'h00E3, "R3 prio7 over 6");
    core_psw = 0;
  endtask

  task automatic t_ack;
    ack_valid = 1; ack_vector = 16'h0047;
    entry(4'd1, 16'h0ABC, 16'h00FE, 16'h0000, 16'h0044, 16'h0DEF, 16'h00E0, "R7 ack override");
    ack_valid = 0; core_psw = 0;
  endtask

  task automatic t_odd_sp;
    entry(4'd5, 16'h1111, 16'h00FF, 16'h0001, 16'h0058, 16'h2222, 16'h00E0, "R5 odd sp");
    chk(mem[16'h00FC >> 1] == 16'h0001 && mem[16'h00FA >> 1] == 16'h1111, "R5 aligned push addresses",
        {mem[16'h00FC >> 1], mem[16'h00FA >> 1]}, {16'h0001, 16'h1111});
    core_psw = 0;
  endtask

  task automatic t_chain;
    bit ok; int bc;
    mem[16'h4C >> 1] = 16'h3000; mem[16'h4E >> 1] = 16'h00A0;
    @(negedge clk);
    core_pc = 16'h0100; core_sp = 16'h00FE; core_psw = 0; irq_lines = 4'd8;
    wait_done(ok, bc);
    chk(ok && new_pc == 16'h3000 && new_psw == 16'h00A0, "R8 first of chain", {new_pc, new_psw}, {16'h3000, 16'h00A0});
    mem[16'h4E >> 1] = 16'h00E0;
    @(negedge clk);
    chk(busy && mem_req && mem_addr == 16'h004C, "R8 chained entry starts at once", {busy, mem_addr}, {1'b1, 16'h004C});
    wait_done(ok, bc);
    chk(ok && new_pc == 16'h3000 && new_psw == 16'h00E0 && new_sp == 16'h00F6, "R8 second of chain",
        {new_pc, new_psw, new_sp}, {16'h3000, 16'h00E0, 16'h00F6});
    chk(mem[16'h00F8 >> 1] == 16'h00A0 && mem[16'h00F6 >> 1] == 16'h3000, "R8 nested context pushed",
        {mem[16'h00F8 >> 1], mem[16'h00F6 >> 1]}, {16'h00A0, 16'h3000});
    irq_lines = 0; core_psw = 0;
    @(negedge clk);
    chk(!busy, "R8 returns idle", busy, 0);
  endtask

  task automatic t_latency;
    bit ok; int bc;
    lat = 3;
    mem[16'h5C >> 1] = 16'h4444; mem[16'h5E >> 1] = 16'h00E0;
    @(negedge clk);
    core_pc = 16'h0200; core_sp = 16'h00FE; core_psw = 0; irq_lines = 4'd4;
    @(negedge clk);
    wait_done(ok, bc);
    chk(ok && bc == 17, "R9 busy cycles with latency 3", bc, 17);
    chk(new_pc == 16'h4444, "R9 result with latency", new_pc, 16'h4444);
    irq_lines = 0; core_psw = 0; lat = 0;
    @(negedge clk);
    @(negedge clk);
    irq_lines = 4'd4;
    @(negedge clk);
    wait_done(ok, bc);
    chk(ok && bc == 5, "R9 busy cycles with latency 0", bc, 5);
    irq_lines = 0; core_psw = 0;
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = 16'hDEAD;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_equal_prio();
    t_table();
    t_prio_boundary();
    t_ack();
    t_odd_sp();
    t_chain();
    t_latency();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #900000;
    fails++; checks++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule